// File: doc/BRIEF.md
# Serial Pattern Word Shifter

This block turns 32-bit patterns written by a host over a 16-bit write bus into a continuous serial bit stream on one output pin. A pattern is delivered as two halfword writes. The first, with the half-select input low, supplies bits 15..0 and is only held. The second, with half-select high, supplies bits 31..16 and commits the whole word. Committed words are kept in four parallel byte-wide lanes, each holding up to four entries.

A three-state controller (idle, load, shift) starts a frame once every lane holds data. It copies one word into a 32-bit shift register and then sends it most significant bit first, one bit per clock, for exactly 32 clocks. A request output tells a DMA engine or interrupt handler when every lane has room for another word. Writes that arrive with no room are discarded and leave a sticky overflow flag.

Top module: `pattern_serializer`

## Requirements
- R1: A synchronous active-high reset empties all lanes, clears the held lower halfword to zero and clears the overflow flag. After reset `req` is 1, `ser_out` is 0 and `ovf` is 0.
- R2: A write with `wr_hi`=0 only stores `wr_data` as the pending bits 15..0 and sends nothing. A later `wr_hi`=0 write replaces the stored value.
- R3: A write with `wr_hi`=1, made while every lane has room, commits the word {`wr_data`, pending lower half} to all four lanes in that clock. Lane k holds bits 8k+7..8k.
- R4: If a word is committed at clock edge E into empty lanes with the controller idle, bit 31 of that word appears on `ser_out` after edge E+2.
- R5: A word is sent MSB first, one bit per clock, for exactly 32 consecutive clocks. Bit 31-k is shown after the k-th shift-state edge.
- R6: `ser_out` is 0 whenever no frame is being shifted.
- R7: While words are waiting, consecutive frames are separated by exactly two clocks (one idle, one load) with `ser_out` low, giving a 34-clock period.
- R8: `req` is 1 exactly when every lane has room for another entry. It is 0 once four words are stored and none has been loaded.
- R9: A write of either half made while `req` is 0 is discarded. It sets `ovf`, which stays 1 until reset, and the discarded word is never sent.
- R10: Words are sent in the order in which they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Halfword write strobe |
| wr_hi | input | 1 | Half select: 0 = bits 15..0 (held), 1 = bits 31..16 (commits) |
| wr_data | input | 16 | Halfword write data |
| ser_out | output | 1 | Serial pattern output, MSB first |
| req | output | 1 | High when all four lanes can accept another word |
| ovf | output | 1 | Sticky flag: a write was discarded for lack of room |

## Verification
The assertions assume the host writes only single-cycle strobes with a defined `wr_hi`, and that `wr_en` stays low during reset. The bench drives every write from a task that raises `wr_en` for one clock at a falling edge and lowers it at the next. It always supplies the lower half before the upper half, except in the scenarios that deliberately repeat a lower write or put a reset between the halves. The overflow scenario writes six words faster than one frame drains. This holds the lanes full long enough for the properties about dropped writes and the sticky flag to be exercised.

// File: rtl/ps_pkg.sv
package ps_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic  valid;
        logic  upper;
        half_t data;
    } half_wr_t;

    function automatic word_t join_halves(input half_t hi, input half_t lo);
        return {hi, lo};
    endfunction

    function automatic lane_t lane_slice(input word_t w, input int idx);
        return w[idx*LANE_W +: LANE_W];
    endfunction

endpackage

// File: rtl/ps_lane_fifo.sv
module ps_lane_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         not_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    assign do_push  = push && (fill != FULL_CNT);
    assign do_pop   = pop && (fill != '0);
    assign empty    = (fill == '0);
    assign not_full = (fill != FULL_CNT);
    assign dout     = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/ps_word_packer.sv
module ps_word_packer
    import ps_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  half_wr_t wr,
    input  logic     all_room,
    output logic     push,
    output word_t    push_word,
    output logic     ovf
);
    half_t low_q;
    logic  accept;

    assign accept    = wr.valid && all_room;
    assign push      = accept && wr.upper;
    assign push_word = join_halves(wr.data, low_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wr.valid && !all_room) begin
                ovf <= 1'b1;
            end
            if (accept) begin
                low_q <= wr.upper ? '0 : wr.data;
            end
        end
    end

endmodule

// File: rtl/ps_shift_engine.sv
module ps_shift_engine
    import ps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lanes_ready,
    input  word_t            lane_word,
    output logic             pop,
    output logic             ser,
    output eng_state_e       state,
    output logic [CNT_W-1:0] bit_cnt
);
    word_t sreg;

    assign pop = (state == ST_LOAD);
    assign ser = (state == ST_SHIFT) && sreg[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sreg    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (lanes_ready) state <= ST_LOAD;
                end
                ST_LOAD: begin
                    sreg    <= lane_word;
                    bit_cnt <= '0;
                    state   <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    sreg    <= {sreg[WORD_W-2:0], 1'b0};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                    if (bit_cnt == LAST_BIT) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pattern_serializer.sv
module pattern_serializer
    import ps_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    output logic              ser_out,
    output logic              req,
    output logic              ovf
);
    half_wr_t         wr;
    logic             push, pop;
    word_t            push_word, lane_word;
    logic [LANES-1:0] lane_empty, lane_room;
    logic             lanes_ready, all_room;
    eng_state_e       eng_state;
    logic [CNT_W-1:0] eng_cnt;

    assign wr          = '{valid: wr_en, upper: wr_hi, data: wr_data};
    assign lanes_ready = ~|lane_empty;
    assign all_room    = &lane_room;
    assign req         = all_room;

    ps_word_packer packer_i (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .all_room  (all_room),
        .push      (push),
        .push_word (push_word),
        .ovf       (ovf)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_t dout_g;
        ps_lane_fifo #(.W(LANE_W), .DEPTH(DEPTH)) fifo_i (
            .clk      (clk),
            .rst      (rst),
            .push     (push),
            .din      (lane_slice(push_word, g)),
            .pop      (pop),
            .dout     (dout_g),
            .empty    (lane_empty[g]),
            .not_full (lane_room[g])
        );
        assign lane_word[g*LANE_W +: LANE_W] = dout_g;
    end

    ps_shift_engine engine_i (
        .clk         (clk),
        .rst         (rst),
        .lanes_ready (lanes_ready),
        .lane_word   (lane_word),
        .pop         (pop),
        .ser         (ser_out),
        .state       (eng_state),
        .bit_cnt     (eng_cnt)
    );

endmodule

// File: rtl/ps_checker.sv
module ps_checker
    import ps_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             req,
    input logic             ovf,
    input eng_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic [LANES-1:0] lane_empty,
    input logic             lanes_ready
);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    a_r9_drop_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !req) |=> ovf);

    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && cnt != LAST_BIT) |=>
        (state == ST_SHIFT && cnt == $past(cnt) + CNT_W'(1)));

    a_r5_frame_end: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && cnt == LAST_BIT) |=> (state == ST_IDLE));

    a_r4_idle_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && lanes_ready) |=> (state == ST_LOAD));

    a_r7_load_once: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |=> (state == ST_SHIFT && cnt == '0));

    a_r3_lanes_agree: assert property (@(posedge clk) disable iff (rst)
        ($countones(lane_empty) == 0) || ($countones(lane_empty) == LANES));

endmodule

bind pattern_serializer ps_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .req         (req),
    .ovf         (ovf),
    .state       (eng_state),
    .cnt         (eng_cnt),
    .lane_empty  (lane_empty),
    .lanes_ready (lanes_ready)
);

// File: tb/pattern_serializer_tb_top.sv
`timescale 1ns/1ps
module pattern_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ser_out, req, ovf;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pattern_serializer dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .ser_out (ser_out),
        .req     (req),
        .ovf     (ovf)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string msg);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", msg, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // one-clock write strobe; returns at the falling edge after the write edge
    task automatic write_half(input logic hi, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_hi   = hi;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // start at the falling edge after the commit edge E; bits follow E+2
    task automatic collect_frame(input logic [31:0] exp, input string msg);
        logic [31:0] acc = '0;
        @(negedge clk);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            acc = {acc[30:0], ser_out};
        end
        check(acc, exp, msg);
        @(negedge clk);
        check(ser_out, 1'b0, "R6 R7 line low in idle gap after frame");
    endtask

    task automatic t_reset_state();
        do_reset();
        check(req, 1'b1, "R1 req high after reset");
        check(ser_out, 1'b0, "R1 ser_out low after reset");
        check(ovf, 1'b0, "R1 ovf low after reset");
    endtask

    task automatic t_single_word();
        do_reset();
        write_half(1'b0, 16'h5A0F);
        write_half(1'b1, 16'hC3A5);
        collect_frame(32'hC3A5_5A0F, "R3 R4 R5 single word MSB first");
        repeat (5) @(negedge clk);
        check(ser_out, 1'b0, "R6 line low when no word waits");
        check(req, 1'b1, "R8 req high with lanes drained");
    endtask

    task automatic t_lower_replace();
        logic seen = 1'b0;
        do_reset();
        write_half(1'b0, 16'h1111);
        write_half(1'b0, 16'hBEEF);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            seen |= ser_out;
        end
        check(seen, 1'b0, "R2 lower writes alone send nothing");
        write_half(1'b1, 16'hDEAD);
        collect_frame(32'hDEAD_BEEF, "R2 latest lower half used");
    endtask

    task automatic t_reset_clears_pending();
        write_half(1'b0, 16'h1234);
        do_reset();
        write_half(1'b1, 16'hABCD);
        collect_frame(32'hABCD_0000, "R1 pending lower half cleared by reset");
    endtask

    task automatic t_overflow_and_order();
        logic [31:0] words [6];
        logic seen = 1'b0;
        words[0] = 32'hFF00_FF00;
        words[1] = 32'hF0F0_F0F0;
        words[2] = 32'hCCCC_CCCC;
        words[3] = 32'hAAAA_AAAA;
        words[4] = 32'h8000_0001;
        words[5] = 32'hFFFF_FFFF;
        do_reset();
        fork
            begin
                for (int i = 0; i < 5; i++) begin
                    write_half(1'b0, words[i][15:0]);
                    write_half(1'b1, words[i][31:16]);
                end
                check(req, 1'b0, "R8 req low with four words stored");
                check(ovf, 1'b0, "R9 ovf still low before drop");
                write_half(1'b0, words[5][15:0]);
                write_half(1'b1, words[5][31:16]);
                check(ovf, 1'b1, "R9 ovf set by write while full");
            end
            begin
                repeat (4) @(negedge clk);
                for (int f = 0; f < 5; f++) begin
                    collect_frame(words[f], "R7 R10 back-to-back frames in order");
                end
            end
        join
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            seen |= ser_out;
        end
        check(seen, 1'b0, "R9 discarded word never sent");
        check(req, 1'b1, "R8 req high again after drain");
        check(ovf, 1'b1, "R9 ovf sticky until reset");
        do_reset();
        check(ovf, 1'b0, "R1 R9 reset clears ovf");
    endtask

    initial begin
        t_reset_state();
        t_single_word();
        t_lower_replace();
        t_reset_clears_pending();
        t_overflow_and_order();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule